// File: doc/BRIEF.md
# Segmented First-One Mask Unit

This block keeps only the first set bit of a 16-bit source mask, scanning from bit 0 upward. An optional predicate vector cuts the bit positions into segments. Each maximal run of consecutive predicate ones, in ascending index order, is its own segment. The search for a first one starts again at the beginning of every segment, so each segment can contribute one set bit of its own. Positions whose predicate bit is zero are never searched.

A zeroing flag picks the value the result starts from while predication is on. With zeroing, the result starts from all zeros. Without zeroing, the result starts from the source itself, and the first bits found are ORed into it. With predication off, the result always starts from zero and both the predicate and the zeroing flag have no effect.

Requests arrive on a valid/ready stream and leave on another. With the output register enabled (the default), a request is accepted whenever the output slot is empty or is being drained in the same cycle. The result then appears with output valid on the next cycle. Back-pressure holds the output and stalls the input. Setting the register parameter to 0 makes the block purely combinational, with valid and ready passed straight through.

Top module: `sof_mask_unit`

## Requirements
- R1: With predication off, the result holds only the lowest-numbered set bit of the source. An all-zero source gives an all-zero result (source 0x0095 gives 0x0001, source 0x0094 gives 0x0004).
- R2: With predication and zeroing both on, no result bit is set where the predicate bit is 0.
- R3: With predication on, each maximal run of consecutive predicate ones is a segment. In each segment, the lowest-indexed set source bit is marked, and the search restarts after every predicate zero (predicate 0x0F0F with source 0xAAAA and zeroing gives 0x0202).
- R4: With predication and zeroing on, the result starts from zero, so it holds exactly the marked bits.
- R5: With predication on and zeroing off, the result starts from the source and the marked bits are ORed into it, so the result equals the source.
- R6: The zeroing flag has no effect while predication is off.
- R7: The predicate vector has no effect while predication is off.
- R8: With the output register enabled, a request accepted at a clock edge (input valid and input ready both high) appears as output valid with its result right after that edge. Output valid drops after the edge where output ready was high, unless a new request was accepted at that edge.
- R9: While output valid is high and output ready is low, output valid stays high, the result stays stable and input ready is low. Input ready equals (not output valid) or output ready.
- R10: During reset and after it, output valid is low until a request is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Request valid |
| in_ready | output | 1 | Block can accept a request |
| src_mask | input | 16 | Source mask vector |
| pred_mask | input | 16 | Predicate vector marking segments |
| pred_en | input | 1 | Predication on |
| zero_en | input | 1 | Zeroing: start from zero instead of the source |
| out_valid | output | 1 | Result valid |
| out_ready | input | 1 | Consumer accepts the result |
| result | output | 16 | Result mask |

## Verification
The hardest case to reach from the ports is a predicate with many short segments. It must line up with source bits that fall both inside and outside them, while a stalled result sits in the output slot with a different request waiting. The table covers alternating and isolated predicate runs, and segments with no source bit. A sweep of four thousand generated predicate and source pairs runs under all four flag settings, with results compared to a behavioural scan loop. A directed stall test holds output ready low while a second request waits on the input.

// File: rtl/sof_pkg.sv
package sof_pkg;
  parameter int unsigned SOF_W = 16;

  typedef enum logic {
    BASE_ZERO = 1'b0,
    BASE_SRC  = 1'b1
  } base_sel_e;
endpackage

// File: rtl/sof_seg_scan.sv
module sof_seg_scan #(
  parameter int unsigned W = sof_pkg::SOF_W
) (
  input  logic [W-1:0] src,
  input  logic [W-1:0] pred,
  input  logic         pred_en,
  input  logic         zero_en,
  output logic [W-1:0] res
);
  import sof_pkg::*;

  base_sel_e      base_sel;
  logic [W-1:0]   base_vec;

  assign base_sel = (pred_en && !zero_en) ? BASE_SRC : BASE_ZERO;
  assign base_vec = (base_sel == BASE_SRC) ? src : '0;

  // Ascending prefix chain: each stage sees whether its segment already found a one.
  for (genvar i = 0; i < W; i++) begin : g_bit
    logic active;
    logic seg_start;
    logic carry_in;
    logic found_before;
    logic hit;
    logic found_out;

    assign active = pred_en ? pred[i] : 1'b1;

    if (i == 0) begin : g_first
      assign seg_start = active;
      assign carry_in  = 1'b0;
    end else begin : g_next
      assign seg_start = active & ~g_bit[i-1].active;
      assign carry_in  = g_bit[i-1].found_out;
    end

    assign found_before = seg_start ? 1'b0 : carry_in;
    assign hit          = active & src[i] & ~found_before;
    assign found_out    = active & (found_before | src[i]);
    assign res[i]       = base_vec[i] | hit;
  end
endmodule

// File: rtl/sof_out_stage.sv
module sof_out_stage #(
  parameter int unsigned W       = sof_pkg::SOF_W,
  parameter bit          REG_OUT = 1'b1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         in_valid,
  output logic         in_ready,
  input  logic [W-1:0] din,
  output logic         out_valid,
  input  logic         out_ready,
  output logic [W-1:0] dout
);
  if (REG_OUT) begin : g_reg
    logic         vld_q;
    logic [W-1:0] data_q;
    logic         take;

    assign in_ready = !vld_q || out_ready;
    assign take     = in_valid && in_ready;

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        vld_q  <= 1'b0;
        data_q <= '0;
      end else begin
        if (take) begin
          vld_q  <= 1'b1;
          data_q <= din;
        end else if (out_ready) begin
          vld_q  <= 1'b0;
        end
      end
    end

    assign out_valid = vld_q;
    assign dout      = data_q;
  end else begin : g_comb
    assign in_ready  = out_ready;
    assign out_valid = in_valid;
    assign dout      = din;
  end
endmodule

// File: rtl/sof_mask_unit.sv
module sof_mask_unit #(
  parameter int unsigned W       = sof_pkg::SOF_W,
  parameter bit          REG_OUT = 1'b1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         in_valid,
  output logic         in_ready,
  input  logic [W-1:0] src_mask,
  input  logic [W-1:0] pred_mask,
  input  logic         pred_en,
  input  logic         zero_en,
  output logic         out_valid,
  input  logic         out_ready,
  output logic [W-1:0] result
);
  logic [W-1:0] scan_res;

  sof_seg_scan #(.W(W)) scan_i (
    .src     (src_mask),
    .pred    (pred_mask),
    .pred_en (pred_en),
    .zero_en (zero_en),
    .res     (scan_res)
  );

  sof_out_stage #(.W(W), .REG_OUT(REG_OUT)) stage_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .in_ready  (in_ready),
    .din       (scan_res),
    .out_valid (out_valid),
    .out_ready (out_ready),
    .dout      (result)
  );
endmodule

// File: rtl/sof_mask_unit_chk.sv
module sof_mask_unit_chk #(
  parameter int unsigned W       = sof_pkg::SOF_W,
  parameter bit          REG_OUT = 1'b1
) (
  input logic         clk,
  input logic         rst_n,
  input logic         in_valid,
  input logic         in_ready,
  input logic [W-1:0] src_mask,
  input logic [W-1:0] pred_mask,
  input logic         pred_en,
  input logic         zero_en,
  input logic         out_valid,
  input logic         out_ready,
  input logic [W-1:0] result,
  input logic [W-1:0] scan_res
);
  logic [W-1:0] lowest_one;
  assign lowest_one = src_mask & (~src_mask + 1'b1);

  a_r1_lowest_only: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && !pred_en) |-> (scan_res == lowest_one));

  a_r2_outside_pred: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && pred_en && zero_en) |-> ((scan_res & ~pred_mask) == '0));

  a_r3_first_seg_bit0: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && pred_en && zero_en && pred_mask[0] && src_mask[0]) |-> scan_res[0]);

  a_r5_merge_keeps_src: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && pred_en && !zero_en) |-> (scan_res == src_mask));

  if (REG_OUT) begin : g_reg_chk
    a_r8_valid_follows: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && in_ready) |=> out_valid);

    a_r9_hold_on_stall: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && !out_ready) |=> (out_valid && $stable(result)));

    a_r9_ready_blocked: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && !out_ready) |-> !in_ready);

    a_r10_reset_idle: assert property (@(posedge clk)
      !rst_n |=> !out_valid);
  end
endmodule

bind sof_mask_unit sof_mask_unit_chk #(.W(W), .REG_OUT(REG_OUT)) chk_i (
  .clk       (clk),
  .rst_n     (rst_n),
  .in_valid  (in_valid),
  .in_ready  (in_ready),
  .src_mask  (src_mask),
  .pred_mask (pred_mask),
  .pred_en   (pred_en),
  .zero_en   (zero_en),
  .out_valid (out_valid),
  .out_ready (out_ready),
  .result    (result),
  .scan_res  (scan_res)
);

// File: tb/sof_mask_unit_tb.sv
module sof_mask_unit_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [15:0] src_mask = '0;
  logic [15:0] pred_mask = '0;
  logic        pred_en = 1'b0;
  logic        zero_en = 1'b0;
  logic        out_valid;
  logic        out_ready = 1'b1;
  logic [15:0] result;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #10 clk = ~clk; // 50 MHz

  sof_mask_unit dut_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .in_ready  (in_ready),
    .src_mask  (src_mask),
    .pred_mask (pred_mask),
    .pred_en   (pred_en),
    .zero_en   (zero_en),
    .out_valid (out_valid),
    .out_ready (out_ready),
    .result    (result)
  );

  // Entry layout: {pred_en, zero_en, pred[15:0], src[15:0], expected[15:0]}
  localparam int NV = 14;
  localparam logic [49:0] TBL [NV] = '{
    {1'b0, 1'b0, 16'h0000, 16'h0095, 16'h0001}, // R1
    {1'b0, 1'b0, 16'h0000, 16'h0094, 16'h0004}, // R1
    {1'b0, 1'b0, 16'h0000, 16'h0000, 16'h0000}, // R1 all zero
    {1'b0, 1'b1, 16'hFFFF, 16'h8000, 16'h8000}, // R6 R7
    {1'b0, 1'b1, 16'h00F0, 16'h0094, 16'h0004}, // R6 R7
    {1'b1, 1'b1, 16'h00C3, 16'h0094, 16'h0080}, // R3 R4
    {1'b1, 1'b1, 16'hFFFF, 16'h0094, 16'h0004}, // R3 single segment
    {1'b1, 1'b1, 16'h5555, 16'hFFFF, 16'h5555}, // R3 isolated segments
    {1'b1, 1'b1, 16'h0F0F, 16'hAAAA, 16'h0202}, // R3 R4
    {1'b1, 1'b1, 16'h0000, 16'hFFFF, 16'h0000}, // R2
    {1'b1, 1'b1, 16'hFF00, 16'h00FF, 16'h0000}, // R2
    {1'b1, 1'b1, 16'hF00F, 16'h8001, 16'h8001}, // R3 edges
    {1'b1, 1'b0, 16'h00C3, 16'h0094, 16'h0094}, // R5
    {1'b1, 1'b0, 16'h0F0F, 16'h0000, 16'h0000}  // R5
  };

  function automatic logic [15:0] ref_sof(input logic [15:0] s, input logic [15:0] p,
                                          input logic pe, input logic ze);
    logic [15:0] r;
    bit seeking;
    bit found;
    r = (pe && !ze) ? s : 16'h0000;
    seeking = !pe;
    found = 1'b0;
    for (int i = 0; i < 16; i++) begin
      if (pe && p[i] && !seeking) begin
        seeking = 1'b1;
        found = 1'b0;
      end
      if (seeking) begin
        if (pe && !p[i]) seeking = 1'b0;
        else if (s[i] && !found) begin
          found = 1'b1;
          r[i] = 1'b1;
        end
      end
    end
    return r;
  endfunction

  task automatic check(input bit ok, input string req, input logic [15:0] act,
                       input logic [15:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=0x%04h expected=0x%04h", req, act, exp);
    end
  endtask

  task automatic drive(input logic pe, input logic ze, input logic [15:0] p,
                       input logic [15:0] s);
    in_valid  = 1'b1;
    pred_en   = pe;
    zero_en   = ze;
    pred_mask = p;
    src_mask  = s;
  endtask

  initial begin
    logic [15:0] prev_exp;
    bit have_prev;
    repeat (3) @(negedge clk);
    // R10: idle during reset
    check(out_valid == 1'b0, "R10 valid in reset", {15'd0, out_valid}, 16'h0000);
    rst_n = 1'b1;
    @(negedge clk);
    check(out_valid == 1'b0, "R10 valid after reset", {15'd0, out_valid}, 16'h0000);
    check(in_ready == 1'b1, "R9 ready when empty", {15'd0, in_ready}, 16'h0001);

    // Table walk: one request per cycle, each checked on the next negedge (R8)
    have_prev = 1'b0;
    prev_exp = '0;
    for (int k = 0; k < NV; k++) begin
      drive(TBL[k][49], TBL[k][48], TBL[k][47:32], TBL[k][31:16]);
      @(negedge clk);
      check(out_valid == 1'b1, "R8 valid next cycle", {15'd0, out_valid}, 16'h0001);
      check(result == TBL[k][15:0], "R1-table R3 R5 vector", result, TBL[k][15:0]);
    end
    in_valid = 1'b0;
    @(negedge clk);
    check(out_valid == 1'b0, "R8 valid drops when drained", {15'd0, out_valid}, 16'h0000);

    // Sweep against the behavioural scan under all four flag settings
    for (int n = 0; n < 4096; n++) begin
      for (int fl = 0; fl < 4; fl++) begin
        logic [15:0] s;
        logic [15:0] p;
        s = 16'(n * 40503) ^ 16'(n >> 3);
        p = 16'(n * 9973 + fl * 4099) ^ 16'(n << 5);
        drive(fl[1], fl[0], p, s);
        @(negedge clk);
        if (have_prev)
          check(result == prev_exp, "R3 sweep vs reference", result, prev_exp);
        prev_exp = ref_sof(s, p, fl[1], fl[0]);
        have_prev = 1'b1;
        // check for the current request happens after this edge pair:
        if (!(out_valid && result == prev_exp))
          check(1'b0, "R8 sweep result", result, prev_exp);
        have_prev = 1'b0;
      end
    end
    in_valid = 1'b0;
    @(negedge clk);

    // R9: stall with a second request waiting
    out_ready = 1'b0;
    drive(1'b1, 1'b1, 16'h0F0F, 16'hAAAA);
    @(negedge clk);
    check(out_valid && result == 16'h0202, "R9 first result captured", result, 16'h0202);
    check(in_ready == 1'b0, "R9 ready low on stall", {15'd0, in_ready}, 16'h0000);
    drive(1'b0, 1'b0, 16'h0000, 16'h0094);
    @(negedge clk);
    check(out_valid && result == 16'h0202, "R9 result held", result, 16'h0202);
    check(in_ready == 1'b0, "R9 ready still low", {15'd0, in_ready}, 16'h0000);
    out_ready = 1'b1;
    @(negedge clk);
    check(out_valid && result == 16'h0004, "R9 waiting request taken", result, 16'h0004);
    in_valid = 1'b0;
    @(negedge clk);
    check(out_valid == 1'b0, "R8 valid clears after drain", {15'd0, out_valid}, 16'h0000);

    // R10: reset mid-stream clears the output slot
    drive(1'b0, 1'b0, 16'h0000, 16'h0001);
    @(negedge clk);
    in_valid = 1'b0;
    out_ready = 1'b0;
    rst_n = 1'b0;
    @(negedge clk);
    check(out_valid == 1'b0, "R10 reset clears valid", {15'd0, out_valid}, 16'h0000);
    rst_n = 1'b1;
    out_ready = 1'b1;
    @(negedge clk);
    check(out_valid == 1'b0, "R10 idle after reset", {15'd0, out_valid}, 16'h0000);

    if (!done) begin
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      checks++;
      failures++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule